// File: doc/BRIEF.md
# Flash buffered-write command sequencer

This block sits behind a flash command port and runs the multi-write sequence that loads a small word buffer and then commits it to the array in one job. The host opens the sequence by writing the buffer-setup command together with an address in the target erase block. The host then reads the extended status to learn whether the buffer was granted. If it was, the host writes the word count, then the first address with its data, then the remaining address/data pairs, and closes the sequence with the confirm command. A copy engine then merges the buffer into an array model word by word. Programming can only clear bits, and the engine verifies each word as it goes.

Every address is range-checked against the start address, the count and the erase block fixed at setup. A sequence that breaks these rules, or that is not closed by confirm, ends with a sequence error. Error bits in the status register stay set until the host issues the clear command, and while they are set the buffer is not granted again. Conditions outside the block's reach are supplied as input flags: the programming supply level, the target block's lock state, the lock override and a fault injection that makes cells refuse to program.

Top module: `fwb_sequencer`

## Requirements
- R1: After reset the status output reads 80h, the extended status reads 80h, and every array word reads FFFFh.
- R2: A write whose low byte is E8h, made while no sequence is open, is granted when status bits 5 and 4 are both clear and no copy is running. A grant sets extended status bit 7 to 1 and opens a sequence for the erase block of that address. If the request is not granted, bit 7 reads 0 and no sequence opens. Extended bits 6..0 always read 0.
- R3: The first write after a grant carries the count as N-1. A value above 15 makes a sequence error, which sets status bits 5 and 4 and closes the sequence.
- R4: The next write gives the start address and first data. The start address must lie in the granted block, and start plus count must not leave that block. Each later address must lie between start and start plus count. Any violation makes a sequence error.
- R5: After N data writes, a confirm write (low byte D0h) starts the copy. Each array word becomes its old value AND the buffer word. Buffer slots that were never written are FFFFh. A later write to the same slot overwrites the earlier one.
- R6: Any write other than D0h in the confirm position makes a sequence error, and the array is left unchanged.
- R7: In the idle state, a write with low byte 50h clears status bits 5, 4, 3 and 1.
- R8: A confirm while the supply flag is low sets status bits 4 and 3 and leaves the array unchanged.
- R9: A confirm while the target block is locked and the override is low sets status bits 4 and 1 and leaves the array unchanged. With the override high, the copy proceeds.
- R10: If a word read back after merging still has a 1 where the buffer has a 0, the copy stops at that word, status bit 4 is set, and no further words are written.
- R11: Status bit 7 reads 0 from the edge that accepts confirm until the edge that writes the last word, which is N cycles for a clean copy. Status bits 6, 2 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| wr_addr | input | 8 | Host write word address |
| wr_data | input | 16 | Host write data; the low byte carries command codes |
| volt_ok | input | 1 | Programming supply valid |
| blk_locked | input | 1 | Lock state of the block being confirmed |
| lock_ovr | input | 1 | Lock override permitted |
| fault_inj | input | 1 | Cells refuse to program while high |
| rd_addr | input | 8 | Array model read address |
| rd_data | output | 16 | Array model word at rd_addr, combinational |
| status | output | 8 | Status: 7 ready, 5 sequence error, 4 program error, 3 supply error, 1 lock error |
| xstatus | output | 8 | Extended status: bit 7 buffer granted |

## Verification
The properties take it as given that the flag inputs hold steady across any confirm cycle and that the host issues at most one write per cycle. They also assume that clear is only issued from the idle state. The stimulus changes flags only while no sequence is open and always leaves a spare cycle between writes. It sets the clear command only after a sequence has ended, so each property sees settled inputs whenever its antecedent fires.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

    localparam logic [7:0] CMD_SETUP   = 8'hE8;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_CLEAR   = 8'h50;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_COUNT   = 3'd1,
        S_FIRST   = 3'd2,
        S_DATA    = 3'd3,
        S_CONFIRM = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic seq;
        logic prog;
        logic volt;
        logic lock;
    } err_t;

    typedef struct packed {
        logic ready;
        logic rsv6;
        logic seq;
        logic prog;
        logic volt;
        logic rsv2;
        logic lock;
        logic rsv0;
    } stat_t;

    function automatic stat_t build_status(input err_t e, input logic rdy);
        stat_t s;
        s       = '0;
        s.ready = rdy;
        s.seq   = e.seq;
        s.prog  = e.prog;
        s.volt  = e.volt;
        s.lock  = e.lock;
        return s;
    endfunction

endpackage

// File: rtl/fwb_wbuf.sv
module fwb_wbuf #(
    parameter int DATA_W = 16,
    parameter int BUF_N  = 16,
    parameter int CNT_W  = $clog2(BUF_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              we,
    input  logic [CNT_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    logic [BUF_N-1:0][DATA_W-1:0] slots;

    for (genvar g = 0; g < BUF_N; g++) begin : g_slot
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                word_q <= '1;
            end else if (we && widx == CNT_W'(g)) begin
                word_q <= wdata;
            end
        end
        assign slots[g] = word_q;
    end

    assign rdata = slots[ridx];

endmodule

// File: rtl/fwb_engine.sv
module fwb_engine #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] job_base,
    input  logic [CNT_W-1:0]  job_last,
    input  logic              fault_inj,
    output logic [CNT_W-1:0]  buf_idx,
    input  logic [DATA_W-1:0] buf_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              fail
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              busy_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  last_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] waddr;
    logic [DATA_W-1:0] cur_word;
    logic [DATA_W-1:0] merged;

    assign waddr    = base_q + ADDR_W'(idx_q);
    assign cur_word = mem_q[waddr];
    // a stuck cell keeps its old value instead of taking the AND
    assign merged   = fault_inj ? cur_word : (cur_word & buf_data);
    assign fail     = busy_q && ((merged & ~buf_data) != '0);
    assign buf_idx  = idx_q;
    assign busy     = busy_q;
    assign rd_data  = mem_q[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            last_q <= '0;
            base_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else if (go) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            last_q <= job_last;
            base_q <= job_base;
        end else if (busy_q) begin
            if (fail) begin
                busy_q <= 1'b0;
            end else begin
                mem_q[waddr] <= merged;
                if (idx_q == last_q) begin
                    busy_q <= 1'b0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fwb_seq_ctrl.sv
module fwb_seq_ctrl
    import fwb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 5,
    parameter int BUF_N  = 16,
    parameter int CNT_W  = $clog2(BUF_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              volt_ok,
    input  logic              blk_locked,
    input  logic              lock_ovr,
    input  logic              eng_busy,
    input  logic              eng_fail,
    output logic              buf_clr,
    output logic              buf_we,
    output logic [CNT_W-1:0]  buf_idx,
    output logic [DATA_W-1:0] buf_wdata,
    output logic              go,
    output logic [ADDR_W-1:0] job_base,
    output logic [CNT_W-1:0]  job_last,
    output logic [7:0]        status_o,
    output logic [7:0]        xstatus_o,
    output seq_state_t        st
);

    localparam int BLK_AW = ADDR_W - BLK_W;
    localparam logic [DATA_W-1:0] CNT_MAX = DATA_W'(BUF_N - 1);

    seq_state_t        st_q, st_d;
    err_t              err_q, err_d;
    logic              xfree_q, xfree_d;
    logic [BLK_AW-1:0] blk_q, blk_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [CNT_W-1:0]  last_q, last_d;
    logic [CNT_W-1:0]  rem_q, rem_d;

    logic [7:0]        cmd;
    logic [ADDR_W:0]   end_sum;
    logic [ADDR_W-1:0] delta;
    logic              first_bad;
    logic              data_bad;
    logic              err_held;

    assign cmd       = wr_data[7:0];
    assign end_sum   = {1'b0, wr_addr} + (ADDR_W + 1)'(last_q);
    assign first_bad = (wr_addr[ADDR_W-1:BLK_W] != blk_q) ||
                       (end_sum[ADDR_W:BLK_W] != {1'b0, blk_q});
    assign delta     = wr_addr - base_q;
    assign data_bad  = (wr_addr < base_q) || (delta > ADDR_W'(last_q));
    assign err_held  = err_q.seq || err_q.prog;

    always_comb begin
        st_d      = st_q;
        err_d     = err_q;
        xfree_d   = xfree_q;
        blk_d     = blk_q;
        base_d    = base_q;
        last_d    = last_q;
        rem_d     = rem_q;
        buf_clr   = 1'b0;
        buf_we    = 1'b0;
        buf_idx   = '0;
        buf_wdata = wr_data;
        go        = 1'b0;

        if (wr_en) begin
            unique case (st_q)
                S_IDLE: begin
                    if (cmd == CMD_SETUP) begin
                        if (err_held || eng_busy) begin
                            xfree_d = 1'b0;
                        end else begin
                            xfree_d = 1'b1;
                            blk_d   = wr_addr[ADDR_W-1:BLK_W];
                            buf_clr = 1'b1;
                            st_d    = S_COUNT;
                        end
                    end else if (cmd == CMD_CLEAR) begin
                        err_d = '0;
                    end
                end
                S_COUNT: begin
                    if (wr_data > CNT_MAX) begin
                        err_d.seq  = 1'b1;
                        err_d.prog = 1'b1;
                        st_d       = S_IDLE;
                    end else begin
                        last_d = wr_data[CNT_W-1:0];
                        st_d   = S_FIRST;
                    end
                end
                S_FIRST: begin
                    if (first_bad) begin
                        err_d.seq  = 1'b1;
                        err_d.prog = 1'b1;
                        st_d       = S_IDLE;
                    end else begin
                        base_d  = wr_addr;
                        buf_we  = 1'b1;
                        buf_idx = '0;
                        rem_d   = last_q;
                        st_d    = (last_q == '0) ? S_CONFIRM : S_DATA;
                    end
                end
                S_DATA: begin
                    if (data_bad) begin
                        err_d.seq  = 1'b1;
                        err_d.prog = 1'b1;
                        st_d       = S_IDLE;
                    end else begin
                        buf_we  = 1'b1;
                        buf_idx = delta[CNT_W-1:0];
                        rem_d   = rem_q - 1'b1;
                        if (rem_q == CNT_W'(1)) begin
                            st_d = S_CONFIRM;
                        end
                    end
                end
                S_CONFIRM: begin
                    st_d = S_IDLE;
                    if (cmd != CMD_CONFIRM) begin
                        err_d.seq  = 1'b1;
                        err_d.prog = 1'b1;
                    end else if (!volt_ok) begin
                        err_d.prog = 1'b1;
                        err_d.volt = 1'b1;
                    end else if (blk_locked && !lock_ovr) begin
                        err_d.prog = 1'b1;
                        err_d.lock = 1'b1;
                    end else begin
                        go = 1'b1;
                    end
                end
                default: st_d = S_IDLE;
            endcase
        end

        if (eng_fail) begin
            err_d.prog = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            err_q   <= '0;
            xfree_q <= 1'b1;
            blk_q   <= '0;
            base_q  <= '0;
            last_q  <= '0;
            rem_q   <= '0;
        end else begin
            st_q    <= st_d;
            err_q   <= err_d;
            xfree_q <= xfree_d;
            blk_q   <= blk_d;
            base_q  <= base_d;
            last_q  <= last_d;
            rem_q   <= rem_d;
        end
    end

    assign job_base  = base_q;
    assign job_last  = last_q;
    assign status_o  = build_status(err_q, !eng_busy);
    assign xstatus_o = {xfree_q, 7'b0};
    assign st        = st_q;

endmodule

// File: rtl/fwb_sequencer.sv
module fwb_sequencer
    import fwb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 5,
    parameter int BUF_N  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              volt_ok,
    input  logic              blk_locked,
    input  logic              lock_ovr,
    input  logic              fault_inj,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [7:0]        status,
    output logic [7:0]        xstatus
);

    localparam int CNT_W = $clog2(BUF_N);

    seq_state_t        seq_st;
    logic              eng_busy;
    logic              eng_fail;
    logic              buf_clr;
    logic              buf_we;
    logic [CNT_W-1:0]  buf_widx;
    logic [DATA_W-1:0] buf_wdata;
    logic [CNT_W-1:0]  buf_ridx;
    logic [DATA_W-1:0] buf_rdata;
    logic              go;
    logic [ADDR_W-1:0] job_base;
    logic [CNT_W-1:0]  job_last;

    fwb_seq_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W), .BUF_N(BUF_N), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .volt_ok   (volt_ok),
        .blk_locked(blk_locked),
        .lock_ovr  (lock_ovr),
        .eng_busy  (eng_busy),
        .eng_fail  (eng_fail),
        .buf_clr   (buf_clr),
        .buf_we    (buf_we),
        .buf_idx   (buf_widx),
        .buf_wdata (buf_wdata),
        .go        (go),
        .job_base  (job_base),
        .job_last  (job_last),
        .status_o  (status),
        .xstatus_o (xstatus),
        .st        (seq_st)
    );

    fwb_wbuf #(
        .DATA_W(DATA_W), .BUF_N(BUF_N), .CNT_W(CNT_W)
    ) u_buf (
        .clk  (clk),
        .rst  (rst),
        .clr  (buf_clr),
        .we   (buf_we),
        .widx (buf_widx),
        .wdata(buf_wdata),
        .ridx (buf_ridx),
        .rdata(buf_rdata)
    );

    fwb_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_eng (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .job_base (job_base),
        .job_last (job_last),
        .fault_inj(fault_inj),
        .buf_idx  (buf_ridx),
        .buf_data (buf_rdata),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .busy     (eng_busy),
        .fail     (eng_fail)
    );

endmodule

// File: rtl/fwb_checker.sv
module fwb_checker
    import fwb_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] cmd,
    input logic       volt_ok,
    input logic       blk_locked,
    input logic       lock_ovr,
    input seq_state_t st,
    input logic       eng_busy,
    input logic       ready,
    input logic       xfree,
    input logic       e_seq,
    input logic       e_prog,
    input logic       e_volt,
    input logic       e_lock
);

    logic confirm_wr;
    assign confirm_wr = wr_en && (st == S_CONFIRM) && (cmd == CMD_CONFIRM);

    p_granted_while_open_r2: assert property (@(posedge clk) disable iff (rst)
        (st == S_COUNT) |-> xfree);

    p_refuse_on_error_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && st == S_IDLE && cmd == CMD_SETUP && (e_seq || e_prog)) |=> !xfree);

    p_bad_confirm_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && st == S_CONFIRM && cmd != CMD_CONFIRM) |=> (e_seq && e_prog));

    p_copy_starts_r11: assert property (@(posedge clk) disable iff (rst)
        (confirm_wr && volt_ok && !(blk_locked && !lock_ovr)) |=> !ready);

    p_supply_error_r8: assert property (@(posedge clk) disable iff (rst)
        (confirm_wr && !volt_ok) |=> (e_prog && e_volt && ready));

    p_lock_error_r9: assert property (@(posedge clk) disable iff (rst)
        (confirm_wr && volt_ok && blk_locked && !lock_ovr) |=> (e_prog && e_lock));

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && st == S_IDLE && cmd == CMD_CLEAR && !eng_busy)
            |=> !(e_seq || e_prog || e_volt || e_lock));

    p_seq_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (e_seq && !(wr_en && st == S_IDLE && cmd == CMD_CLEAR)) |=> e_seq);

endmodule

bind fwb_sequencer fwb_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .cmd       (wr_data[7:0]),
    .volt_ok   (volt_ok),
    .blk_locked(blk_locked),
    .lock_ovr  (lock_ovr),
    .st        (seq_st),
    .eng_busy  (eng_busy),
    .ready     (status[7]),
    .xfree     (xstatus[7]),
    .e_seq     (status[5]),
    .e_prog    (status[4]),
    .e_volt    (status[3]),
    .e_lock    (status[1])
);

// File: tb/sim_fwb_sequencer.sv
module sim_fwb_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        w_en = 1'b0;
    logic [7:0]  w_addr = '0;
    logic [15:0] w_data = '0;
    logic        w_volt = 1'b1;
    logic        w_lock = 1'b0;
    logic        w_ovr = 1'b0;
    logic        w_fault = 1'b0;
    logic [7:0]  rd_a = '0;
    logic [15:0] rd_data;
    logic [7:0]  status;
    logic [7:0]  xstatus;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit finished = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    fwb_sequencer u0 (
        .clk(clk), .rst(rst), .wr_en(w_en), .wr_addr(w_addr), .wr_data(w_data),
        .volt_ok(w_volt), .blk_locked(w_lock), .lock_ovr(w_ovr), .fault_inj(w_fault),
        .rd_addr(rd_a), .rd_data(rd_data), .status(status), .xstatus(xstatus)
    );

    // behavioural reference: 0 idle, 1 count, 2 first, 3 data, 4 confirm
    int          m_phase;
    bit          m_e5, m_e4, m_e3, m_e1, m_free;
    bit          m_busy;
    int          m_blk, m_start, m_cnt, m_left, m_pos;
    logic [15:0] m_buf [16];
    logic [15:0] m_mem [256];

    function automatic logic [7:0] exp_status();
        return {~m_busy, 1'b0, m_e5, m_e4, m_e3, 1'b0, m_e1, 1'b0};
    endfunction

    task automatic seq_fail();
        m_e5 = 1; m_e4 = 1; m_phase = 0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_e5 = 0; m_e4 = 0; m_e3 = 0; m_e1 = 0; m_free = 1;
            m_busy = 0; m_pos = 0; m_blk = 0; m_start = 0; m_cnt = 0; m_left = 0;
            foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
            foreach (m_buf[i]) m_buf[i] = 16'hFFFF;
        end else begin
            bit was_busy, bad;
            int wa, off;
            logic [15:0] after;
            was_busy = m_busy;
            bad = 0; wa = 0; after = '0;
            if (was_busy) begin
                wa = (m_start + m_pos) % 256;
                after = w_fault ? m_mem[wa] : (m_mem[wa] & m_buf[m_pos]);
                bad = ((after & ~m_buf[m_pos]) != 16'h0);
            end
            if (w_en) begin
                case (m_phase)
                    0: begin
                        if (w_data[7:0] == 8'hE8) begin
                            if (m_e5 || m_e4 || was_busy) m_free = 0;
                            else begin
                                m_free = 1; m_blk = w_addr / 32; m_phase = 1;
                                foreach (m_buf[i]) m_buf[i] = 16'hFFFF;
                            end
                        end else if (w_data[7:0] == 8'h50) begin
                            m_e5 = 0; m_e4 = 0; m_e3 = 0; m_e1 = 0;
                        end
                    end
                    1: begin
                        if (w_data > 16'd15) seq_fail();
                        else begin m_cnt = w_data; m_phase = 2; end
                    end
                    2: begin
                        if (w_addr / 32 != m_blk || (w_addr + m_cnt) / 32 != m_blk) seq_fail();
                        else begin
                            m_start = w_addr; m_buf[0] = w_data; m_left = m_cnt;
                            m_phase = (m_cnt == 0) ? 4 : 3;
                        end
                    end
                    3: begin
                        off = int'(w_addr) - m_start;
                        if (off < 0 || off > m_cnt) seq_fail();
                        else begin
                            m_buf[off] = w_data; m_left--;
                            if (m_left == 0) m_phase = 4;
                        end
                    end
                    default: begin
                        m_phase = 0;
                        if (w_data[7:0] != 8'hD0) begin m_e5 = 1; m_e4 = 1; end
                        else if (!w_volt) begin m_e4 = 1; m_e3 = 1; end
                        else if (w_lock && !w_ovr) begin m_e4 = 1; m_e1 = 1; end
                        else begin m_busy = 1; m_pos = 0; end
                    end
                endcase
            end
            if (was_busy) begin
                if (bad) begin m_busy = 0; m_e4 = 1; end
                else begin
                    m_mem[wa] = after;
                    if (m_pos == m_cnt) m_busy = 0; else m_pos++;
                end
            end
        end
        #2;
        compared++;
        if (status !== exp_status()) begin
            mismatched++;
            $display("FAIL %s status: got %h expected %h", tag, status, exp_status());
        end
        compared++;
        if (xstatus !== {m_free, 7'b0}) begin
            mismatched++;
            $display("FAIL %s xstatus: got %h expected %h", tag, xstatus, {m_free, 7'b0});
        end
        compared++;
        if (rd_data !== m_mem[rd_a]) begin
            mismatched++;
            $display("FAIL %s array[%h]: got %h expected %h", tag, rd_a, rd_data, m_mem[rd_a]);
        end
    end

    always @(negedge clk) rd_a <= rd_a + 8'd1;

    task automatic hw(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        w_en = 1'b1; w_addr = a; w_data = d;
        @(negedge clk);
        w_en = 1'b0;
    endtask

    task automatic pause(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                compared++;
                mismatched++;
                $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
                report();
            end
        end
    end

    initial begin
        pause(3);
        rst = 1'b0;
        tag = "R1"; pause(3);

        // full four-word job in block 1, then a setup while the copy runs
        tag = "R5";
        hw(8'h20, 16'h00E8); hw(8'h20, 16'd3);
        hw(8'h22, 16'h1234); hw(8'h23, 16'hABCD); hw(8'h24, 16'h0F0F); hw(8'h25, 16'h8001);
        tag = "R11"; hw(8'h20, 16'h00D0);
        tag = "R2"; hw(8'h20, 16'h00E8);
        pause(8);

        // overlapping job: repeated slot, skipped slot, AND with old data
        tag = "R5";
        hw(8'h22, 16'h00E8); hw(8'h22, 16'd3);
        hw(8'h22, 16'hFF00); hw(8'h25, 16'h00FF); hw(8'h25, 16'h0F00); hw(8'h23, 16'h7777);
        hw(8'h22, 16'h00D0); pause(8);
        hw(8'h50, 16'h00E8); hw(8'h50, 16'd0); hw(8'h5F, 16'h5555); hw(8'h5F, 16'h00D0);
        pause(4);

        tag = "R6";
        hw(8'h40, 16'h00E8); hw(8'h40, 16'd1); hw(8'h40, 16'h0000); hw(8'h41, 16'h0000);
        hw(8'h40, 16'h00FF); pause(2);
        tag = "R7";
        hw(8'h40, 16'h00E8); hw(8'h44, 16'h0000); hw(8'h00, 16'h0050);
        hw(8'h40, 16'h00E8);
        tag = "R3"; hw(8'h40, 16'h0020); pause(2);
        tag = "R7"; hw(8'h00, 16'h0050);

        tag = "R4";
        hw(8'h40, 16'h00E8); hw(8'h40, 16'd3); hw(8'h60, 16'h0000); hw(8'h00, 16'h0050);
        hw(8'h40, 16'h00E8); hw(8'h40, 16'd3); hw(8'h5E, 16'h0000); hw(8'h00, 16'h0050);
        hw(8'h40, 16'h00E8); hw(8'h40, 16'd3); hw(8'h44, 16'h0000); hw(8'h43, 16'h0000);
        hw(8'h00, 16'h0050);
        hw(8'h40, 16'h00E8); hw(8'h40, 16'd2); hw(8'h44, 16'h0000); hw(8'h47, 16'h0000);
        hw(8'h00, 16'h0050);

        tag = "R8";
        w_volt = 1'b0;
        hw(8'h48, 16'h00E8); hw(8'h48, 16'd0); hw(8'h48, 16'h0000); hw(8'h48, 16'h00D0);
        w_volt = 1'b1; pause(2); hw(8'h00, 16'h0050);

        tag = "R9";
        w_lock = 1'b1;
        hw(8'h49, 16'h00E8); hw(8'h49, 16'd0); hw(8'h49, 16'h0000); hw(8'h49, 16'h00D0);
        pause(2); hw(8'h00, 16'h0050);
        w_ovr = 1'b1;
        hw(8'h49, 16'h00E8); hw(8'h49, 16'd0); hw(8'h49, 16'h1111); hw(8'h49, 16'h00D0);
        pause(3); w_lock = 1'b0; w_ovr = 1'b0;

        tag = "R10";
        w_fault = 1'b1;
        hw(8'h60, 16'h00E8); hw(8'h60, 16'd1); hw(8'h60, 16'h0000); hw(8'h61, 16'h0000);
        hw(8'h60, 16'h00D0); pause(4);
        w_fault = 1'b0; hw(8'h00, 16'h0050);

        tag = "R5"; pause(260);
        report();
    end

endmodule